// File: doc/BRIEF.md
# Programmable Sample-Rate Clock

This block turns a 1 MHz reference enable into sample strobes at a programmed rate. A chain of decade prescalers derives 100 kHz, 10 kHz, 1 kHz and 100 Hz enables from the reference. A rate field in the configuration word picks one of these enables, the raw reference, rising edges of an external trigger, or rising edges of a line-frequency tick as the timebase. A 16-bit counter is clocked by that timebase. In the interval modes the counter counts down from a programmed preset and raises a strobe each time it expires. So a sample rate F on the 1 MHz base needs a preset of 1,000,000 / F.

In the event-timing modes the counter counts timebase ticks upward without stopping. Each rising edge of the external trigger captures the count and raises a strobe. A zero-based variant also clears the count after each capture. The counter can be started by an enable bit, or armed by the first external edge. Two sticky interrupt flags report strobes and external edges, and one acknowledge input clears both.

Top module: `rate_clock_unit`

## Requirements
- R1: After reset, `sample_strobe`, `mode_irq` and `ext_irq` are low, and `count_val` and `capture_val` are zero.
- R2: A `cfg_load` pulse stores `cfg_word` and `cfg_preset` and restarts the prescaler chain. On the next cycle `count_val` equals the preset in the interval modes (mode field `cfg_word[9:8]` 0 or 1) and zero in the event modes (2 or 3).
- R3: Rate field `cfg_word[3:1]` values 2, 3, 4 and 5 give one timebase tick per 10, 100, 1000 and 10000 `ref_tick` pulses, counted from the last load. Value 1 uses every `ref_tick` pulse.
- R4: Rate value 6 ticks on each rising edge of `ext_in`, and value 7 on each rising edge of `line_in`. Rate value 0 produces no ticks, so `count_val` holds.
- R5: In repeat mode (mode 1), each tick that finds the count at 1 reloads the preset. It also raises `sample_strobe` for one cycle, in the cycle after that tick. Otherwise a tick decrements the count.
- R6: In single mode (mode 0), the first expiry raises one strobe and leaves the count at 0. No further strobe follows until the next load.
- R7: A preset of 0 in the interval modes gives a period of 65536 ticks.
- R8: In event mode 2, a rising edge of `ext_in` copies the current count to `capture_val` and raises a strobe. Counting continues, and a tick in the same cycle is still counted.
- R9: In event mode 3, a rising edge of `ext_in` captures the count and strobes. The count then restarts from 0, and a tick in the same cycle is dropped.
- R10: With enable bit `cfg_word[0]` clear and the external-gate bit `cfg_word[13]` clear, ticks do not change the count and no strobe occurs.
- R11: With `cfg_word[13]` set and `cfg_word[0]` clear, the counter stays idle until the first `ext_in` rising edge after the load. It runs from the following cycle on.
- R12: With `cfg_word[6]` set, every strobe sets `mode_irq` in the strobe cycle. The flag stays set until `irq_ack`, and a new strobe in the same cycle as `irq_ack` wins over the acknowledge.
- R13: With `cfg_word[14]` set, every `ext_in` rising edge sets `ext_irq` in any mode. The flag is sticky, cleared by `irq_ack`, and a set wins over `irq_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load configuration word and preset |
| cfg_word | input | 16 | Configuration: enable, rate, interrupt enables, mode, external gate |
| cfg_preset | input | 16 | Interval length in timebase ticks |
| ref_tick | input | 1 | 1 MHz single-cycle enable |
| line_in | input | 1 | Line-frequency tick level |
| ext_in | input | 1 | External trigger level |
| irq_ack | input | 1 | Clears both interrupt flags |
| sample_strobe | output | 1 | One-cycle sample pulse |
| mode_irq | output | 1 | Sticky strobe interrupt flag |
| ext_irq | output | 1 | Sticky external-edge interrupt flag |
| count_val | output | 16 | Current counter value |
| capture_val | output | 16 | Last count captured on an external edge |

## Verification
The assertions assume that every input is synchronous to `clk`, that `ref_tick` is a single-cycle enable, and that `cfg_load` is not raised in a cycle that also carries a timebase tick or an `ext_in` edge. The stimulus keeps to these rules. It changes every input only on the falling edge. Each load cycle holds `ref_tick`, `line_in` and `ext_in` low, and the trigger and line inputs are pulsed high for single cycles. Within those rules the bench sweeps every rate code and every mode. It also covers both gate sources, coincident edges and ticks, and acknowledges that arrive together with a new interrupt.

// File: rtl/rclk_pkg.sv
package rclk_pkg;

  localparam int RCLK_CFG_W   = 16;
  localparam int RCLK_DECADES = 4;

  // bit positions the decoder relies on
  localparam int BIT_ENABLE   = 0;
  localparam int BIT_RATE_LSB = 1;
  localparam int BIT_MODE_IRQ = 6;
  localparam int BIT_MODE_LSB = 8;
  localparam int BIT_EXT_GATE = 13;
  localparam int BIT_EXT_IRQ  = 14;

  typedef enum logic [2:0] {
    RATE_OFF  = 3'd0,
    RATE_1M   = 3'd1,
    RATE_100K = 3'd2,
    RATE_10K  = 3'd3,
    RATE_1K   = 3'd4,
    RATE_100  = 3'd5,
    RATE_EXT  = 3'd6,
    RATE_LINE = 3'd7
  } rclk_rate_e;

  typedef enum logic [1:0] {
    MODE_ONCE       = 2'd0,
    MODE_REPEAT     = 2'd1,
    MODE_EVENT      = 2'd2,
    MODE_EVENT_ZERO = 2'd3
  } rclk_mode_e;

  typedef struct packed {
    logic       ext_irq_en;
    logic       ext_gate;
    rclk_mode_e mode;
    logic       mode_irq_en;
    rclk_rate_e rate;
    logic       enable;
  } rclk_cfg_t;

  function automatic rclk_cfg_t decode_cfg(input logic [RCLK_CFG_W-1:0] w);
    rclk_cfg_t c;
    c.enable      = w[BIT_ENABLE];
    c.rate        = rclk_rate_e'(w[BIT_RATE_LSB +: 3]);
    c.mode_irq_en = w[BIT_MODE_IRQ];
    c.mode        = rclk_mode_e'(w[BIT_MODE_LSB +: 2]);
    c.ext_gate    = w[BIT_EXT_GATE];
    c.ext_irq_en  = w[BIT_EXT_IRQ];
    return c;
  endfunction

  function automatic logic is_event_mode(input rclk_mode_e m);
    return (m == MODE_EVENT) || (m == MODE_EVENT_ZERO);
  endfunction

endpackage

// File: rtl/rclk_edge_det.sv
module rclk_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_in,
  output logic [N-1:0] rise_out
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_in;
  end

  assign rise_out = lvl_in & ~prev_q;

endmodule

// File: rtl/rclk_prescaler.sv
module rclk_prescaler #(
  parameter int DECADE = 10,
  parameter int STAGES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            tick_in,
  output logic [STAGES:0] tick_vec
);

  localparam int DW = (DECADE > 2) ? $clog2(DECADE) : 1;
  localparam logic [DW-1:0] LAST = DW'(DECADE - 1);

  assign tick_vec[0] = tick_in;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (restart)     cnt_q <= '0;
      else if (tick_vec[g]) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign tick_vec[g+1] = tick_vec[g] && (cnt_q == LAST);
  end

endmodule

// File: rtl/rclk_timebase.sv
module rclk_timebase
  import rclk_pkg::*;
#(
  parameter int DECADE = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  rclk_rate_e rate,
  input  logic       ref_tick,
  input  logic       ext_edge,
  input  logic       line_edge,
  output logic       tb_tick
);

  logic [RCLK_DECADES:0] dec_ticks;

  rclk_prescaler #(
    .DECADE (DECADE),
    .STAGES (RCLK_DECADES)
  ) u_prescaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .tick_in  (ref_tick),
    .tick_vec (dec_ticks)
  );

  always_comb begin
    unique case (rate)
      RATE_1M:   tb_tick = dec_ticks[0];
      RATE_100K: tb_tick = dec_ticks[1];
      RATE_10K:  tb_tick = dec_ticks[2];
      RATE_1K:   tb_tick = dec_ticks[3];
      RATE_100:  tb_tick = dec_ticks[4];
      RATE_EXT:  tb_tick = ext_edge;
      RATE_LINE: tb_tick = line_edge;
      default:   tb_tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/rclk_counter.sv
module rclk_counter
  import rclk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  rclk_cfg_t        cfg_new,
  input  logic [CNT_W-1:0] preset_new,
  input  logic             tb_tick,
  input  logic             ext_edge,
  output rclk_cfg_t        cfg_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] capture_q,
  output logic             strobe_q,
  output logic             expire_ev,
  output logic             latch_ev,
  output logic             run_gate
);

  logic [CNT_W-1:0] preset_q;
  logic             running_q;
  logic             armed_q;
  logic             evt_mode;

  function automatic logic interval_expires(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] count_up(input logic [CNT_W-1:0] c,
                                                input logic inc);
    return c + {{(CNT_W-1){1'b0}}, inc};
  endfunction

  assign evt_mode  = is_event_mode(cfg_q.mode);
  assign run_gate  = cfg_q.enable | (cfg_q.ext_gate & armed_q);
  assign expire_ev = !evt_mode && running_q && run_gate && tb_tick && interval_expires(cnt_q);
  assign latch_ev  = evt_mode && run_gate && ext_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      preset_q  <= '0;
      cnt_q     <= '0;
      capture_q <= '0;
      strobe_q  <= 1'b0;
      running_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (cfg_load) begin
        cfg_q     <= cfg_new;
        preset_q  <= preset_new;
        cnt_q     <= is_event_mode(cfg_new.mode) ? '0 : preset_new;
        running_q <= 1'b1;
        armed_q   <= 1'b0;
      end else begin
        if (ext_edge) armed_q <= 1'b1;
        if (evt_mode) begin
          if (latch_ev) begin
            capture_q <= cnt_q;
            strobe_q  <= 1'b1;
            cnt_q     <= (cfg_q.mode == MODE_EVENT_ZERO) ? '0 : count_up(cnt_q, tb_tick);
          end else if (run_gate && tb_tick) begin
            cnt_q <= count_up(cnt_q, 1'b1);
          end
        end else if (running_q && run_gate && tb_tick) begin
          if (expire_ev) begin
            strobe_q <= 1'b1;
            if (cfg_q.mode == MODE_REPEAT) begin
              cnt_q <= preset_q;
            end else begin
              cnt_q     <= '0;
              running_q <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_tick && !cfg_load && !latch_ev) |=> $stable(cnt_q));

  assert_gate_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_gate && !cfg_load) |=> !strobe_q);

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_ev && cfg_q.mode == MODE_REPEAT && !cfg_load) |=> (strobe_q && cnt_q == preset_q));

  assert_single_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_ev && cfg_q.mode == MODE_ONCE && !cfg_load) |=> (strobe_q && !running_q && cnt_q == '0));

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_ev && !cfg_load) |=> (strobe_q && capture_q == $past(cnt_q)));

endmodule

// File: rtl/rate_clock_unit.sv
module rate_clock_unit
  import rclk_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DECADE = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_load,
  input  logic [RCLK_CFG_W-1:0] cfg_word,
  input  logic [CNT_W-1:0]      cfg_preset,
  input  logic                  ref_tick,
  input  logic                  line_in,
  input  logic                  ext_in,
  input  logic                  irq_ack,
  output logic                  sample_strobe,
  output logic                  mode_irq,
  output logic                  ext_irq,
  output logic [CNT_W-1:0]      count_val,
  output logic [CNT_W-1:0]      capture_val
);

  localparam int EDGE_N = 2;

  rclk_cfg_t         cfg_new;
  rclk_cfg_t         cfg_q;
  logic [EDGE_N-1:0] rises;
  logic              ext_edge;
  logic              line_edge;
  logic              tb_tick;
  logic              expire_ev;
  logic              latch_ev;
  logic              run_gate;
  logic              strobe_set;
  logic              ext_set;
  logic              mode_irq_q;
  logic              ext_irq_q;

  assign cfg_new = decode_cfg(cfg_word);

  rclk_edge_det #(.N(EDGE_N)) u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_in   ({line_in, ext_in}),
    .rise_out (rises)
  );

  assign ext_edge  = rises[0];
  assign line_edge = rises[1];

  rclk_timebase #(.DECADE(DECADE)) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (cfg_load),
    .rate      (cfg_q.rate),
    .ref_tick  (ref_tick),
    .ext_edge  (ext_edge),
    .line_edge (line_edge),
    .tb_tick   (tb_tick)
  );

  rclk_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load   (cfg_load),
    .cfg_new    (cfg_new),
    .preset_new (cfg_preset),
    .tb_tick    (tb_tick),
    .ext_edge   (ext_edge),
    .cfg_q      (cfg_q),
    .cnt_q      (count_val),
    .capture_q  (capture_val),
    .strobe_q   (sample_strobe),
    .expire_ev  (expire_ev),
    .latch_ev   (latch_ev),
    .run_gate   (run_gate)
  );

  assign strobe_set = (expire_ev | latch_ev) & cfg_q.mode_irq_en;
  assign ext_set    = ext_edge & cfg_q.ext_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_irq_q <= 1'b0;
      ext_irq_q  <= 1'b0;
    end else begin
      if (strobe_set)   mode_irq_q <= 1'b1;
      else if (irq_ack) mode_irq_q <= 1'b0;
      if (ext_set)      ext_irq_q  <= 1'b1;
      else if (irq_ack) ext_irq_q  <= 1'b0;
    end
  end

  assign mode_irq = mode_irq_q;
  assign ext_irq  = ext_irq_q;

  assert_mode_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && cfg_q.mode_irq_en && !$past(cfg_load)) |-> mode_irq);

  assert_ext_irq_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_edge && cfg_q.ext_irq_en) |=> ext_irq);

  assert_ack_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !strobe_set && !ext_set) |=> (!mode_irq && !ext_irq));

endmodule

// File: tb/rate_clock_unit_bench.sv
`timescale 1ns/1ps
module rate_clock_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_word = '0;
  logic [15:0] cfg_preset = '0;
  logic        ref_tick = 1'b0;
  logic        line_in = 1'b0;
  logic        ext_in = 1'b0;
  logic        irq_ack = 1'b0;
  logic        sample_strobe, mode_irq, ext_irq;
  logic [15:0] count_val, capture_val;

  always #10 clk = ~clk;

  rate_clock_unit u_rate_clock_unit (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .cfg_preset(cfg_preset), .ref_tick(ref_tick), .line_in(line_in),
    .ext_in(ext_in), .irq_ack(irq_ack), .sample_strobe(sample_strobe),
    .mode_irq(mode_irq), .ext_irq(ext_irq), .count_val(count_val),
    .capture_val(capture_val)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct packed {
    logic        strobe;
    logic        mirq;
    logic        eirq;
    logic [15:0] cnt;
    logic [15:0] cap;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  event  sample_ev;

  // reference state, built from the requirements
  logic [15:0] m_cfg = '0;
  logic [15:0] m_preset = '0;
  logic [15:0] m_cnt = '0;
  logic [15:0] m_cap = '0;
  bit m_run = 0, m_armed = 0, m_mirq = 0, m_eirq = 0, m_pe = 0, m_pl = 0;
  int m_us = 0;

  function automatic logic [15:0] mk(bit en, int rate, bit mfie, int mode, bit xg, bit xi);
    return 16'(en) | 16'(rate << 1) | 16'(mfie << 6) | 16'(mode << 8)
         | 16'(xg << 13) | 16'(xi << 14);
  endfunction

  always @(sample_ev) begin
    exp_t  e;
    string r;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL scoreboard empty: act=none exp=item");
    end else begin
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if (sample_strobe !== e.strobe || mode_irq !== e.mirq || ext_irq !== e.eirq ||
          count_val !== e.cnt || capture_val !== e.cap) begin
        failures++;
        $display("FAIL %s: act strobe=%0b mirq=%0b eirq=%0b cnt=%0d cap=%0d exp strobe=%0b mirq=%0b eirq=%0b cnt=%0d cap=%0d",
                 r, sample_strobe, mode_irq, ext_irq, count_val, capture_val,
                 e.strobe, e.mirq, e.eirq, e.cnt, e.cap);
      end
    end
  end

  task automatic push_and_sample(input bit strobe, input string req);
    exp_q.push_back({strobe, m_mirq, m_eirq, m_cnt, m_cap});
    req_q.push_back(req);
    @(posedge clk);
    #5;
    ->sample_ev;
  endtask

  task automatic load(input logic [15:0] w, input logic [15:0] p, input string req);
    @(negedge clk);
    cfg_load = 1'b1; cfg_word = w; cfg_preset = p;
    ref_tick = 1'b0; line_in = 1'b0; ext_in = 1'b0; irq_ack = 1'b0;
    m_cfg = w; m_preset = p;
    m_cnt = w[9] ? 16'd0 : p;
    m_run = 1; m_armed = 0; m_us = 0; m_pe = 0; m_pl = 0;
    push_and_sample(1'b0, req);
  endtask

  task automatic step(input bit rt, input bit ln, input bit ex, input bit ack, input string req);
    bit xe, le, tb, gate, strobe;
    int div;
    @(negedge clk);
    cfg_load = 1'b0; ref_tick = rt; line_in = ln; ext_in = ex; irq_ack = ack;
    xe = ex && !m_pe; le = ln && !m_pl; m_pe = ex; m_pl = ln;
    tb = 0;
    if (rt) m_us++;
    case (int'(m_cfg[3:1]))
      1: tb = rt;
      2, 3, 4, 5: begin
        div = 1;
        for (int k = 1; k < int'(m_cfg[3:1]); k++) div = div * 10;
        tb = rt && (m_us % div == 0);
      end
      6: tb = xe;
      7: tb = le;
      default: tb = 0;
    endcase
    gate = m_cfg[0] || (m_cfg[13] && m_armed);
    strobe = 0;
    if (m_cfg[9]) begin
      if (gate && xe) begin
        m_cap = m_cnt; strobe = 1;
        m_cnt = m_cfg[8] ? 16'd0 : m_cnt + 16'(tb);
      end else if (gate && tb) m_cnt = m_cnt + 16'd1;
    end else if (m_run && gate && tb) begin
      if (m_cnt == 16'd1) begin
        strobe = 1;
        if (m_cfg[8]) m_cnt = m_preset;
        else begin m_cnt = 16'd0; m_run = 0; end
      end else m_cnt = m_cnt - 16'd1;
    end
    if (xe) m_armed = 1;
    if (strobe && m_cfg[6]) m_mirq = 1; else if (ack) m_mirq = 0;
    if (xe && m_cfg[14])    m_eirq = 1; else if (ack) m_eirq = 0;
    push_and_sample(strobe, req);
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, req);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #2;
    checks++;
    if (sample_strobe !== 1'b0 || mode_irq !== 1'b0 || ext_irq !== 1'b0 ||
        count_val !== 16'd0 || capture_val !== 16'd0) begin
      failures++;
      $display("FAIL R1: act strobe=%0b cnt=%0d cap=%0d exp strobe=0 cnt=0 cap=0",
               sample_strobe, count_val, capture_val);
    end

    // R2 load, R5 repeat at 1 MHz
    load(mk(1, 1, 0, 1, 0, 0), 16'd3, "R2");
    ticks(9, "R5");
    // R6 single shot
    load(mk(1, 1, 0, 0, 0, 0), 16'd2, "R6");
    ticks(6, "R6");
    // R3 decade rates
    load(mk(1, 2, 0, 1, 0, 0), 16'd2, "R3");
    ticks(45, "R3");
    load(mk(1, 3, 0, 1, 0, 0), 16'd1, "R3");
    ticks(250, "R3");
    load(mk(1, 4, 0, 1, 0, 0), 16'd1, "R3");
    ticks(2050, "R3");
    load(mk(1, 5, 0, 1, 0, 0), 16'd1, "R3");
    ticks(10010, "R3");
    // R4 rate off, external and line sources
    load(mk(1, 0, 0, 1, 0, 0), 16'd5, "R4");
    ticks(10, "R4");
    load(mk(1, 6, 0, 1, 0, 0), 16'd2, "R4");
    for (int i = 0; i < 8; i++) step(1, 0, i % 2 == 0, 0, "R4");
    load(mk(1, 7, 0, 1, 0, 0), 16'd2, "R4");
    for (int i = 0; i < 8; i++) step(1, i % 2 == 0, 0, 0, "R4");
    // R7 preset zero gives 65536 ticks
    load(mk(1, 1, 0, 1, 0, 0), 16'd0, "R7");
    ticks(65540, "R7");
    // R10 counter disabled
    load(mk(0, 1, 0, 1, 0, 0), 16'd2, "R10");
    ticks(5, "R10");
    step(0, 0, 1, 0, "R10");
    ticks(3, "R10");
    // R11 external gate
    load(mk(0, 1, 0, 1, 1, 0), 16'd2, "R11");
    ticks(3, "R11");
    step(0, 0, 1, 0, "R11");
    ticks(5, "R11");
    // R8 event mode, capture with and without coincident tick
    load(mk(1, 1, 0, 2, 0, 0), 16'd0, "R8");
    ticks(5, "R8");
    step(0, 0, 1, 0, "R8");
    ticks(3, "R8");
    step(1, 0, 1, 0, "R8");
    ticks(2, "R8");
    // R9 zero-based event mode
    load(mk(1, 1, 0, 3, 0, 0), 16'd0, "R9");
    ticks(4, "R9");
    step(1, 0, 1, 0, "R9");
    ticks(3, "R9");
    step(0, 0, 1, 0, "R9");
    ticks(2, "R9");
    // R12 strobe interrupt, ack, set wins over ack
    load(mk(1, 1, 1, 1, 0, 0), 16'd2, "R12");
    ticks(3, "R12");
    step(0, 0, 0, 1, "R12");
    step(1, 0, 0, 0, "R12");
    step(1, 0, 0, 1, "R12");
    step(0, 0, 0, 0, "R12");
    step(0, 0, 0, 1, "R12");
    // R13 external interrupt
    load(mk(1, 1, 0, 1, 0, 1), 16'd9, "R13");
    step(0, 0, 1, 0, "R13");
    step(0, 0, 0, 0, "R13");
    step(0, 0, 0, 1, "R13");
    step(0, 0, 1, 1, "R13");
    step(0, 0, 0, 1, "R13");

    repeat (2) @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule